// File: doc/BRIEF.md
# Punctured Convolutional Encoder

This block turns a serial stream of information bits into a serial stream of coded bits for a broadcast transmit chain. Each accepted bit goes through a constraint-length-7, rate-1/2 shift-register encoder that forms two parity bits, X and Y. A puncturing stage then drops some of these bits according to a keep pattern for the selected code rate, so the stream can be sent at rate 1/2, 2/3, 3/4, 5/6 or 7/8. The surviving bits leave one per cycle through a ready/valid output.

A rate select input picks the pattern. The selection is taken only at the start of a pattern period, so a period is never mixed between two rates. A small bit buffer between the puncturer and the output absorbs the varying number of bits produced per input: zero, one or two bits go in per accepted input and one bit goes out per cycle. The input ready falls when the buffer could not take a full pair.

Top module: `pcenc_top`

## Requirements
- R1: After reset, out_valid is low, in_ready is high and the encoder history is all zeros, so the first coded bits depend only on the bits accepted since reset.
- R2: For each accepted bit b with earlier accepted bits d1 (most recent) to d6, X is the XOR of b, d1, d2, d3 and d6 (generator 171 octal), and Y is the XOR of b, d2, d3, d5 and d6 (generator 133 octal).
- R3: rate_sel code 0 selects rate 1/2: every input emits X and then Y.
- R4: rate_sel code 1 selects rate 2/3 with a period of 2 inputs. Keep pattern by position: X=10, Y=11.
- R5: rate_sel code 2 selects rate 3/4 with a period of 3 inputs. Keep pattern: X=101, Y=110.
- R6: rate_sel code 3 selects rate 5/6 with a period of 5 inputs. Keep pattern: X=10101, Y=11010.
- R7: rate_sel code 4 selects rate 7/8 with a period of 7 inputs. Keep pattern: X=1000101, Y=1111010. At every rate, when both bits of one input are kept, X leaves before Y.
- R8: rate_sel is adopted only for an input accepted at pattern position 0. Inputs at other positions use the rate adopted at the start of their period, whatever rate_sel shows then.
- R9: in_ready is high only while the buffer has room for two more bits. An input offered while in_ready is low is not taken, and no coded bit is lost or duplicated.
- R10: While out_valid is high and out_ready is low, out_valid stays high and out_bit holds its value.
- R11: rate_sel codes 5, 6 and 7 behave as rate 1/2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rate_sel | input | 3 | Code rate select (0: 1/2, 1: 2/3, 2: 3/4, 3: 5/6, 4: 7/8, 5 to 7: 1/2) |
| in_valid | input | 1 | Information bit is offered |
| in_bit | input | 1 | Information bit |
| in_ready | output | 1 | Block can accept an information bit this cycle |
| out_valid | output | 1 | A coded bit is on out_bit |
| out_bit | output | 1 | Coded bit |
| out_ready | input | 1 | Downstream takes out_bit this cycle |

## Verification
The coded bits of an input are written into the buffer on the edge that accepts it, so the first of them can be shown on out_bit from the next cycle onward. in_ready reflects the buffer fill left by the previous edge. The bench drives its inputs just after the falling edge and then evaluates both handshakes. At that point the values are exactly those the next rising edge will see. A reference model appends the expected bits for an accepted input, and each output handshake pops and compares one bit in that same half cycle. Stall checks compare out_bit on consecutive cycles, and the number of inputs taken before in_ready falls is compared with the buffer capacity.

// File: rtl/pcenc_pkg.sv
package pcenc_pkg;

  localparam int           CONSTR_LEN = 7;
  localparam logic [6:0]   GEN_X      = 7'o171;
  localparam logic [6:0]   GEN_Y      = 7'o133;
  localparam int           POS_W      = 3;

  typedef enum logic [2:0] {
    RATE_1_2 = 3'd0,
    RATE_2_3 = 3'd1,
    RATE_3_4 = 3'd2,
    RATE_5_6 = 3'd3,
    RATE_7_8 = 3'd4
  } rate_e;

  function automatic rate_e rate_decode(input logic [2:0] code);
    case (code)
      3'd1:    return RATE_2_3;
      3'd2:    return RATE_3_4;
      3'd3:    return RATE_5_6;
      3'd4:    return RATE_7_8;
      default: return RATE_1_2;
    endcase
  endfunction

  function automatic logic [POS_W-1:0] rate_period(input rate_e r);
    case (r)
      RATE_2_3: return 3'd2;
      RATE_3_4: return 3'd3;
      RATE_5_6: return 3'd5;
      RATE_7_8: return 3'd7;
      default:  return 3'd1;
    endcase
  endfunction

  // keep masks, bit i = pattern position i
  function automatic logic [6:0] mask_x(input rate_e r);
    case (r)
      RATE_2_3: return 7'b0000001;
      RATE_3_4: return 7'b0000101;
      RATE_5_6: return 7'b0010101;
      RATE_7_8: return 7'b1010001;
      default:  return 7'b0000001;
    endcase
  endfunction

  function automatic logic [6:0] mask_y(input rate_e r);
    case (r)
      RATE_2_3: return 7'b0000011;
      RATE_3_4: return 7'b0000011;
      RATE_5_6: return 7'b0001011;
      RATE_7_8: return 7'b0101111;
      default:  return 7'b0000001;
    endcase
  endfunction

endpackage

// File: rtl/pcenc_rst_sync.sv
module pcenc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/pcenc_conv_core.sv
module pcenc_conv_core #(
  parameter int         CL = 7,
  parameter logic [6:0] GX = 7'o171,
  parameter logic [6:0] GY = 7'o133
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din,
  output logic x,
  output logic y
);

  localparam int SR_W = CL - 1;

  logic [SR_W-1:0] sr_q, sr_d;
  logic [CL-1:0]   window;

  // window[CL-1] is the current bit, window[CL-1-k] the bit k inputs back
  assign window = {din, sr_q};
  assign x      = ^(window & GX);
  assign y      = ^(window & GY);

  always_comb begin
    sr_d = sr_q;
    if (en) sr_d = {din, sr_q[SR_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

endmodule

// File: rtl/pcenc_punct_ctl.sv
module pcenc_punct_ctl
  import pcenc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [2:0]       rate_sel,
  output logic             keep_x,
  output logic             keep_y,
  output logic [POS_W-1:0] pos,
  output logic [2:0]       act_rate
);

  rate_e            rate_q, rate_d, rate_eff;
  logic [POS_W-1:0] pos_q, pos_d;
  logic [6:0]       mx, my;

  // a new selection is only looked at on position 0
  assign rate_eff = (pos_q == '0) ? rate_decode(rate_sel) : rate_q;
  assign mx       = mask_x(rate_eff);
  assign my       = mask_y(rate_eff);
  assign keep_x   = mx[pos_q];
  assign keep_y   = my[pos_q];
  assign pos      = pos_q;
  assign act_rate = rate_q;

  always_comb begin
    rate_d = rate_q;
    pos_d  = pos_q;
    if (adv) begin
      rate_d = rate_eff;
      if (pos_q == rate_period(rate_eff) - 3'd1) pos_d = '0;
      else                                        pos_d = pos_q + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= RATE_1_2;
      pos_q  <= '0;
    end else begin
      rate_q <= rate_d;
      pos_q  <= pos_d;
    end
  end

endmodule

// File: rtl/pcenc_bit_fifo.sv
module pcenc_bit_fifo #(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  push_n,
  input  logic        push_b0,
  input  logic        push_b1,
  input  logic        pop,
  output logic        dout,
  output logic [AW:0] level
);

  localparam logic [AW-1:0] ONE = 1;

  logic [DEPTH-1:0] mem;
  logic [AW-1:0]    wr_q, wr_d, rd_q, rd_d;
  logic [AW:0]      lvl_q, lvl_d;

  assign dout  = mem[rd_q];
  assign level = lvl_q;

  always_comb begin
    wr_d  = wr_q + AW'(push_n);
    rd_d  = pop ? rd_q + ONE : rd_q;
    lvl_d = lvl_q + (AW+1)'(push_n) - (AW+1)'(pop);
  end

  always_ff @(posedge clk) begin
    if (push_n != 2'd0) mem[wr_q]       <= push_b0;
    if (push_n == 2'd2) mem[wr_q + ONE] <= push_b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      lvl_q <= lvl_d;
    end
  end

endmodule

// File: rtl/pcenc_top.sv
module pcenc_top
  import pcenc_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] rate_sel,
  input  logic       in_valid,
  input  logic       in_bit,
  output logic       in_ready,
  output logic       out_valid,
  output logic       out_bit,
  input  logic       out_ready
);

  localparam int AW = $clog2(DEPTH);

  logic             rst_ns;
  logic             accept, enc_x, enc_y, keep_x, keep_y, pop;
  logic [1:0]       push_n;
  logic             push_b0, push_b1;
  logic [AW:0]      fill_lvl;
  logic [POS_W-1:0] pat_pos;
  logic [2:0]       act_rate;

  pcenc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ns)
  );

  assign in_ready  = (fill_lvl <= (AW+1)'(DEPTH - 2));
  assign accept    = in_valid & in_ready;
  assign out_valid = (fill_lvl != '0);
  assign pop       = out_valid & out_ready;

  pcenc_conv_core #(.CL(CONSTR_LEN), .GX(GEN_X), .GY(GEN_Y)) u_core (
    .clk   (clk),
    .rst_n (rst_ns),
    .en    (accept),
    .din   (in_bit),
    .x     (enc_x),
    .y     (enc_y)
  );

  pcenc_punct_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_ns),
    .adv      (accept),
    .rate_sel (rate_sel),
    .keep_x   (keep_x),
    .keep_y   (keep_y),
    .pos      (pat_pos),
    .act_rate (act_rate)
  );

  // survivors are packed in X-then-Y order
  always_comb begin
    push_n  = 2'd0;
    push_b0 = enc_x;
    push_b1 = enc_y;
    if (accept) begin
      if (keep_x && keep_y) push_n = 2'd2;
      else if (keep_x)      push_n = 2'd1;
      else if (keep_y) begin
        push_n  = 2'd1;
        push_b0 = enc_y;
      end
    end
  end

  pcenc_bit_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_ns),
    .push_n  (push_n),
    .push_b0 (push_b0),
    .push_b1 (push_b1),
    .pop     (pop),
    .dout    (out_bit),
    .level   (fill_lvl)
  );

endmodule

// File: rtl/pcenc_checker.sv
module pcenc_checker
  import pcenc_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_ns,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_bit,
  input logic [AW:0]      fill,
  input logic [POS_W-1:0] pos,
  input logic [2:0]       act_rate
);

  // R9: the buffer never holds more than its depth
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_ns)
    fill <= (AW+1)'(DEPTH));

  // R9: a refused input adds nothing to the buffer
  a_r9_refused_no_push: assert property (@(posedge clk) disable iff (!rst_ns)
    (in_valid && !in_ready) |=> (fill <= $past(fill)));

  // R10: a stalled output holds
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_ns)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));

  // R8: the adopted rate is frozen away from position 0
  a_r8_rate_locked: assert property (@(posedge clk) disable iff (!rst_ns)
    (pos != '0) |=> $stable(act_rate));

  // R4: the pattern position stays inside the period of the adopted rate
  a_r4_pos_in_period: assert property (@(posedge clk) disable iff (!rst_ns)
    pos < rate_period(rate_decode(act_rate)));

endmodule

bind pcenc_top pcenc_checker #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_ns    (rst_ns),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_bit   (out_bit),
  .fill      (fill_lvl),
  .pos       (pat_pos),
  .act_rate  (act_rate)
);

// File: tb/sim_pcenc_top.sv
`timescale 1ns/1ps
module sim_pcenc_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] rate_sel;
  logic       in_valid, in_bit, in_ready;
  logic       out_valid, out_bit, out_ready;

  always #4 clk = ~clk;

  pcenc_top u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .rate_sel  (rate_sel),
    .in_valid  (in_valid),
    .in_bit    (in_bit),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_bit   (out_bit),
    .out_ready (out_ready)
  );

  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;
  string tag = "R1";

  // reference model state
  int    hist[$];
  bit    expq[$];
  int    m_rate = 0;
  int    m_pos = 0;
  int    taken = 0;
  string px[5] = '{"1", "10", "101", "10101", "1000101"};
  string py[5] = '{"1", "11", "110", "11010", "1111010"};
  localparam int GX = 'o171;
  localparam int GY = 'o133;

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sel_to_idx(input int code);
    return (code >= 1 && code <= 4) ? code : 0;
  endfunction

  function automatic int parity(input int g, input int b);
    int p = b;
    for (int k = 1; k <= 6; k++)
      if (((g >> (6 - k)) & 1) != 0 && k <= hist.size()) p ^= hist[k-1];
    return p;
  endfunction

  task automatic model_accept(input int b);
    int r, xb, yb;
    r = (m_pos == 0) ? sel_to_idx(int'(rate_sel)) : m_rate;
    m_rate = r;
    xb = parity(GX, b);
    yb = parity(GY, b);
    if (px[r].getc(m_pos) == "1") expq.push_back(xb[0]);
    if (py[r].getc(m_pos) == "1") expq.push_back(yb[0]);
    m_pos = (m_pos + 1 == px[r].len()) ? 0 : m_pos + 1;
    hist.push_front(b);
    if (hist.size() > 6) void'(hist.pop_back());
    taken++;
  endtask

  task automatic step(input bit v, input bit b, input bit ordy, input logic [2:0] rs);
    @(negedge clk);
    in_valid  = v;
    in_bit    = b;
    out_ready = ordy;
    rate_sel  = rs;
    #1;
    if (out_valid && out_ready) begin
      if (expq.size() == 0) check(tag, 1, 0, "unexpected output bit");
      else check(tag, int'(out_bit), int'(expq.pop_front()), "coded bit");
    end
    if (in_valid && in_ready) model_accept(int'(in_bit));
  endtask

  task automatic drain(input logic [2:0] rs);
    for (int i = 0; i < 200 && expq.size() != 0; i++) step(1'b0, 1'b0, 1'b1, rs);
    step(1'b0, 1'b0, 1'b1, rs);
    check(tag, int'(out_valid), 0, "buffer empty after drain");
    check(tag, expq.size(), 0, "all expected bits seen");
  endtask

  task automatic run_rate(input string t, input logic [2:0] rs, input int n, input bit rnd_ready);
    tag = t;
    for (int i = 0; i < n; i++)
      step(1'b1, 1'($urandom), rnd_ready ? 1'($urandom) : 1'b1, rs);
    drain(rs);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=expired expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    string tg[5] = '{"R3", "R4", "R5", "R6", "R7"};
    bit held;
    rst_n = 1'b0; in_valid = 1'b0; in_bit = 1'b0; out_ready = 1'b0; rate_sel = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R1: reset state
    check("R1", int'(out_valid), 0, "out_valid after reset");
    check("R1", int'(in_ready), 1, "in_ready after reset");

    // R2: impulse response from the zero history
    tag = "R2";
    step(1'b1, 1'b1, 1'b1, 3'd0);
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 1'b1, 3'd0);
    drain(3'd0);

    // R3..R7: each rate, first with free output then with a random stall
    for (int r = 0; r < 5; r++) begin
      run_rate(tg[r], 3'(r), 42, 1'b0);
      run_rate(tg[r], 3'(r), 70, 1'b1);
    end

    // R8: rate_sel changes on every cycle
    tag = "R8";
    for (int i = 0; i < 300; i++)
      step(1'b1, 1'($urandom), 1'($urandom), 3'($urandom % 5));
    drain(3'd0);

    // R11: unused codes behave as rate 1/2
    for (int c = 5; c < 8; c++) run_rate("R11", 3'(c), 30, 1'b1);

    // R9 and R10: output stalled, input offered continuously at rate 1/2
    tag = "R9";
    taken = 0;
    step(1'b1, 1'b1, 1'b0, 3'd0);
    step(1'b1, 1'b0, 1'b0, 3'd0);
    held = out_bit;
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 1'($urandom), 1'b0, 3'd0);
      check("R10", int'(out_bit), int'(held), "out_bit held during stall");
      check("R10", int'(out_valid), 1, "out_valid held during stall");
    end
    check("R9", taken, DEPTH_INPUTS, "inputs taken before in_ready fell");
    check("R9", int'(in_ready), 0, "in_ready low when buffer full");
    drain(3'd0);

    done = 1'b1;
    summary();
    $finish;
  end

  localparam int DEPTH_INPUTS = 4;

endmodule